// File: doc/BRIEF.md
# Capture FIFO with DMA Threshold Request

This block is the word buffer that sits between the pixel packer of an image capture path and the bus or DMA engine that empties it. Each stored word is 32 bits and there are 128 entries. All logic runs on one clock. The packer pushes words in. The reader pops them through a registered read port. The DMA request rises once the number of stored words reaches a programmable threshold.

The block shows its occupancy on several outputs. It reports the current level, both raw pointers, and a high-water mark of the largest level seen since reset or the last clear. It also gives status outputs for non-empty, full and threshold reached, plus one-cycle pulses for rejected writes (overflow) and rejected reads (underflow).

A test mode lets software fill the buffer through the bus write port and then read it back. In test mode the packer's writes are ignored.

Top module: `capfifo_top`

## Requirements
- R1: An accepted write stores its word at `wr_ptr` and advances `wr_ptr` by one. An accepted read advances `rd_ptr` by one. Both pointers count 0 to 127 and wrap to 0, and words come out in the order they went in.
- R2: `level` equals the number of stored words (0 to 128). It goes up by one on an accepted write alone, down by one on an accepted read alone, and is unchanged when both are accepted in the same cycle.
- R3: `peak` holds the largest value `level` has taken since reset or the last clear. It never decreases otherwise.
- R4: The threshold is `thr_code + 1` (a `thr_code` of 0 means 1, and 127 means 128). `ev_thresh` is high exactly while `level` is at least the threshold.
- R5: `dma_req` is high exactly while `dma_en` is 1 and `level` is at least the threshold. It falls in the same cycle that `level` drops below the threshold or `dma_en` is cleared.
- R6: `ev_nonempty` is high exactly while `level` is not 0. `ev_full` is high exactly while `level` is 128.
- R7: A write while full with no read in the same cycle is dropped: `wr_ptr` and `level` do not change, and `ev_overflow` is high for the next cycle only. If a read is accepted in the same cycle, the write is accepted.
- R8: A read while empty is rejected: `rd_ptr` does not change, `rd_data` becomes 0, and `ev_underflow` is high for the next cycle only. A write in the same cycle is still accepted.
- R9: After an accepted read, `rd_data` shows the oldest word from the next cycle on, and holds it until the next read or clear.
- R10: With `test_en` = 1, writes come only from `bus_wr`/`bus_wdata` and `pk_wr` is ignored. With `test_en` = 0, writes come only from `pk_wr`/`pk_data` and `bus_wr` is ignored.
- R11: `clr` = 1 at a clock edge sets the pointers, `level`, `peak` and `rd_data` to 0 and drops any read or write in that cycle; no overflow or underflow pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of pointers, level and peak |
| test_en | input | 1 | Selects the bus write port as the write source |
| pk_wr | input | 1 | Packer write strobe |
| pk_data | input | 32 | Packer write word |
| bus_wr | input | 1 | Bus write strobe (test mode only) |
| bus_wdata | input | 32 | Bus write word |
| bus_rd | input | 1 | Read strobe from bus or DMA |
| rd_data | output | 32 | Registered read word |
| dma_en | input | 1 | Enables the DMA request |
| thr_code | input | 7 | Threshold code, threshold = code + 1 |
| level | output | 8 | Stored word count |
| peak | output | 8 | Highest level since reset or clear |
| wr_ptr | output | 7 | Write pointer |
| rd_ptr | output | 7 | Read pointer |
| dma_req | output | 1 | DMA request |
| ev_nonempty | output | 1 | Level is not zero |
| ev_full | output | 1 | Level is 128 |
| ev_thresh | output | 1 | Level has reached the threshold |
| ev_overflow | output | 1 | Pulse after a dropped write |
| ev_underflow | output | 1 | Pulse after a rejected read |

## Verification
The embedded properties check several invariants on every cycle: the pointer distance always matches the level, the level never exceeds 128, and the peak never falls below the level or its own earlier value. They also check that dropped writes and rejected reads leave their pointer unchanged and produce a pulse, and that the write source ignored in each mode moves nothing. Only the bench scenarios can show that the words come back in write order across pointer wraparound. The same holds for the exact threshold edge for every one of the 128 codes, the behaviour of a simultaneous read and write at full and at empty, and the effect of a clear issued together with a write.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;
  localparam int unsigned CF_DATA_W = 32;
  localparam int unsigned CF_DEPTH  = 128;

  typedef struct packed {
    logic nonempty;
    logic full;
    logic thresh;
  } cf_stat_t;
endpackage

// File: rtl/capfifo_mem.sv
module capfifo_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/capfifo_ctrl.sv
module capfifo_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_pulse,
  output logic              udf_pulse
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [ADDR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d, pk_q, pk_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              ovf_q, ovf_d, udf_q, udf_d;
  logic              rd_ok, wr_ok, empty_now;

  // next-state
  always_comb begin
    empty_now = (lvl_q == '0);
    rd_ok     = rd_req && !empty_now;
    wr_ok     = wr_req && ((lvl_q != FULL_LVL) || rd_ok);
    wp_d      = wp_q;
    rp_d      = rp_q;
    lvl_d     = lvl_q;
    rdat_d    = rdat_q;
    if (wr_ok) begin
      wp_d = wp_q + ADDR_W'(1);
    end
    if (rd_ok) begin
      rp_d   = rp_q + ADDR_W'(1);
      rdat_d = mem_rdata;
    end else if (rd_req) begin
      rdat_d = '0;
    end
    unique case ({wr_ok, rd_ok})
      2'b10:   lvl_d = lvl_q + LVL_W'(1);
      2'b01:   lvl_d = lvl_q - LVL_W'(1);
      default: lvl_d = lvl_q;
    endcase
    pk_d  = (lvl_d > pk_q) ? lvl_d : pk_q;
    ovf_d = wr_req && !wr_ok;
    udf_d = rd_req && empty_now;
    if (clr) begin
      wp_d   = '0;
      rp_d   = '0;
      lvl_d  = '0;
      pk_d   = '0;
      rdat_d = '0;
      ovf_d  = 1'b0;
      udf_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lvl_q  <= '0;
      pk_q   <= '0;
      rdat_q <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      lvl_q  <= lvl_d;
      pk_q   <= pk_d;
      rdat_q <= rdat_d;
      ovf_q  <= ovf_d;
      udf_q  <= udf_d;
    end
  end

  assign mem_we    = wr_ok && !clr;
  assign wr_ptr    = wp_q;
  assign rd_ptr    = rp_q;
  assign level     = lvl_q;
  assign peak      = pk_q;
  assign rd_data   = rdat_q;
  assign ovf_pulse = ovf_q;
  assign udf_pulse = udf_q;

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ADDR_W'(wp_q - rp_q) == lvl_q[ADDR_W-1:0]); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL_LVL); // R2
  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    pk_q >= lvl_q); // R3
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> pk_q >= $past(pk_q)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !rd_req && !clr && lvl_q == FULL_LVL)
      |=> (ovf_q && $stable(wp_q) && lvl_q == FULL_LVL)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !clr && lvl_q == '0)
      |=> (udf_q && $stable(rp_q) && rdat_q == '0)); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lvl_q == '0 && pk_q == '0 && !ovf_q && !udf_q)); // R11
endmodule

// File: rtl/capfifo_flags.sv
module capfifo_flags
  import capfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level,
  input  logic [ADDR_W-1:0] thr_code,
  input  logic              dma_en,
  output cf_stat_t          stat,
  output logic              dma_req
);
  logic [LVL_W-1:0] thr_val;
  logic             reached;

  always_comb begin
    thr_val       = {1'b0, thr_code} + LVL_W'(1);
    reached       = (level >= thr_val);
    stat.nonempty = (level != '0);
    stat.full     = (level == LVL_W'(DEPTH));
    stat.thresh   = reached;
    dma_req       = dma_en && reached;
  end

  AST_FULL_IMPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    stat.full |-> (stat.thresh && stat.nonempty)); // R6
  AST_THRESH_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !stat.nonempty |-> (!stat.thresh && !dma_req)); // R4
endmodule

// File: rtl/capfifo_top.sv
module capfifo_top
  import capfifo_pkg::*;
#(
  parameter int unsigned DATA_W = CF_DATA_W,
  parameter int unsigned DEPTH  = CF_DEPTH,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              test_en,
  input  logic              pk_wr,
  input  logic [DATA_W-1:0] pk_data,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] thr_code,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              dma_req,
  output logic              ev_nonempty,
  output logic              ev_full,
  output logic              ev_thresh,
  output logic              ev_overflow,
  output logic              ev_underflow
);
  logic              wr_sel;
  logic [DATA_W-1:0] wdata_sel;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  cf_stat_t          stat;

  always_comb begin
    wr_sel    = test_en ? bus_wr    : pk_wr;
    wdata_sel = test_en ? bus_wdata : pk_data;
  end

  capfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_ptr),
    .wdata (wdata_sel),
    .raddr (rd_ptr),
    .rdata (mem_rdata)
  );

  capfifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .wr_req    (wr_sel),
    .rd_req    (bus_rd),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .level     (level),
    .peak      (peak),
    .rd_data   (rd_data),
    .ovf_pulse (ev_overflow),
    .udf_pulse (ev_underflow)
  );

  capfifo_flags #(.DEPTH(DEPTH)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .thr_code (thr_code),
    .dma_en   (dma_en),
    .stat     (stat),
    .dma_req  (dma_req)
  );

  assign ev_nonempty = stat.nonempty;
  assign ev_full     = stat.full;
  assign ev_thresh   = stat.thresh;

  AST_TEST_IGNORES_PACKER: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !bus_wr && !clr) |=> $stable(wr_ptr)); // R10
  AST_NORMAL_IGNORES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !pk_wr && !clr) |=> $stable(wr_ptr)); // R10
endmodule

// File: tb/capfifo_top_tb_top.sv
module capfifo_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        clr, test_en, pk_wr, bus_wr, bus_rd, dma_en;
  logic [31:0] pk_data, bus_wdata, rd_data;
  logic [6:0]  thr_code, wr_ptr, rd_ptr;
  logic [7:0]  level, peak;
  logic        dma_req, ev_nonempty, ev_full, ev_thresh, ev_overflow, ev_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mmem [128];
  int mlevel = 0, mpeak = 0, mwp = 0, mrp = 0, seq = 0;
  logic [31:0] mrdata = '0;
  bit movf = 0, mudf = 0;

  capfifo_top dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .test_en(test_en),
    .pk_wr(pk_wr), .pk_data(pk_data), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .rd_data(rd_data), .dma_en(dma_en), .thr_code(thr_code),
    .level(level), .peak(peak), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .dma_req(dma_req), .ev_nonempty(ev_nonempty), .ev_full(ev_full),
    .ev_thresh(ev_thresh), .ev_overflow(ev_overflow), .ev_underflow(ev_underflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state();
    int thr;
    thr = int'(thr_code) + 1;
    chk(int'(level) == mlevel, "R2 level", level, mlevel);
    chk(int'(wr_ptr) == mwp, "R1 wr_ptr", wr_ptr, mwp);
    chk(int'(rd_ptr) == mrp, "R1 rd_ptr", rd_ptr, mrp);
    chk(int'(peak) == mpeak, "R3 peak", peak, mpeak);
    chk(rd_data == mrdata, "R9 rd_data", rd_data, mrdata);
    chk(ev_overflow == movf, "R7 overflow", ev_overflow, movf);
    chk(ev_underflow == mudf, "R8 underflow", ev_underflow, mudf);
    chk(ev_nonempty == (mlevel != 0), "R6 nonempty", ev_nonempty, mlevel != 0);
    chk(ev_full == (mlevel == 128), "R6 full", ev_full, mlevel == 128);
    chk(ev_thresh == (mlevel >= thr), "R4 thresh", ev_thresh, mlevel >= thr);
    chk(dma_req == (dma_en && mlevel >= thr), "R5 dma_req", dma_req, dma_en && mlevel >= thr);
  endtask

  // one clock with the given strobes; inputs set just after a falling edge
  task automatic op(input bit p_w, input bit b_w, input bit rd, input bit c);
    bit wsel, rok, wok;
    logic [31:0] d;
    seq++;
    d = {8'hC3, 24'(seq * 7919)};
    pk_wr = p_w; bus_wr = b_w; bus_rd = rd; clr = c;
    pk_data = d; bus_wdata = ~d;
    wsel = test_en ? b_w : p_w;
    rok  = rd && (mlevel > 0);
    wok  = wsel && ((mlevel < 128) || rok);
    if (c) begin
      mlevel = 0; mpeak = 0; mwp = 0; mrp = 0; mrdata = '0; movf = 0; mudf = 0;
    end else begin
      movf = wsel && !wok;
      mudf = rd && (mlevel == 0);
      if (rok) begin mrdata = mmem[mrp]; mrp = (mrp + 1) % 128; end
      else if (rd) mrdata = '0;
      if (wok) begin mmem[mwp] = test_en ? ~d : d; mwp = (mwp + 1) % 128; end
      mlevel = mlevel + (wok ? 1 : 0) - (rok ? 1 : 0);
      if (mlevel > mpeak) mpeak = mlevel;
    end
    @(posedge clk);
    @(negedge clk);
    pk_wr = 0; bus_wr = 0; bus_rd = 0; clr = 0;
    #2;
    check_state();
  endtask

  // every threshold code against the current level
  task automatic sweep_thr();
    logic [6:0] saved;
    saved = thr_code;
    for (int code = 0; code < 128; code++) begin
      thr_code = 7'(code);
      #2;
      chk(ev_thresh == (mlevel >= code + 1), "R4 sweep thresh", ev_thresh, mlevel >= code + 1);
      chk(dma_req == (dma_en && mlevel >= code + 1), "R5 sweep dma_req", dma_req,
          dma_en && mlevel >= code + 1);
      @(negedge clk);
    end
    thr_code = saved;
    #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; test_en = 0; pk_wr = 0; bus_wr = 0; bus_rd = 0;
    dma_en = 1; thr_code = 7'd9; pk_data = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    check_state(); // reset state, R1 R2 R3 R6

    for (int i = 0; i < 128; i++) op(1, 0, 0, 0);     // fill, R1 R2 R4 R5
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0);       // dropped writes, R7
    sweep_thr();
    dma_en = 0; #2; sweep_thr(); dma_en = 1; #2;     // R5 gating
    for (int i = 0; i < 4; i++) op(1, 0, 1, 0);       // read+write at full, R7
    for (int i = 0; i < 60; i++) op(0, 0, 1, 0);      // drain partly, R9
    sweep_thr();
    for (int i = 0; i < 400; i++) op(i % 3 != 2, 0, i % 2 == 0, 0); // wrap, R1
    while (mlevel > 0) op(0, 0, 1, 0);
    op(0, 0, 1, 0); op(0, 0, 1, 0);                   // underflow, R8
    sweep_thr();
    op(1, 0, 1, 0);                                   // write kept at empty, R8
    sweep_thr();
    test_en = 1;
    for (int i = 0; i < 5; i++) op(1, 0, 0, 0);       // packer ignored, R10
    for (int i = 0; i < 6; i++) op(0, 1, 0, 0);       // bus writes, R10
    for (int i = 0; i < 4; i++) op(0, 0, 1, 0);       // read back, R10 R9
    test_en = 0;
    for (int i = 0; i < 5; i++) op(0, 1, 0, 0);       // bus ignored, R10
    op(1, 0, 1, 1);                                   // clear with ops, R11
    for (int i = 0; i < 12; i++) op(1, 0, 0, 0);
    while (mlevel > 0) op(0, 0, 1, 0);                // R1 order after clear

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule